// File: doc/BRIEF.md
# Packed Time-of-Day Counter with Alarm and Stopwatch

This block keeps wall-clock time as a single packed word: seconds, minutes, hours and a running day count sit in fixed bit fields, and the whole word advances by one second on each slow tick (the 1 Hz strobe from the prescaler). On every advance it reports which field boundaries were crossed. It also compares the new time against a stored alarm word in two ways: one that looks only at the time of day and one that also requires the day count to match.

A separate down-counting stopwatch shares the same tick and raises its own flag when it runs out. A write unit loads new time, alarm and stopwatch values. All event flags are single-cycle strobes meant to be ORed into a sticky status register elsewhere. There is no calendar: days are a plain binary count.

Top module: `packed_tod_counter`

## Requirements
- R1: After reset the time word, the alarm word and the stopwatch count are all zero, and no event strobe is active.
- R2: The time word packs seconds in bits 5:0, minutes in 11:6, hours in 16:12 and days in 31:17. Each tick without a load adds one second. Seconds and minutes return to 0 after 59 and hours after 23, each wrap carrying one into the next field. The new time is visible in the cycle after the tick.
- R3: On an advancing tick, event bit 2 pulses. Bit 3 pulses when the seconds wrap, bit 4 when the minutes wrap and bit 5 when the hours wrap.
- R4: Event bit 1 pulses on an advancing tick when bits 16:0 of the new time equal bits 16:0 of the alarm word. The day field is ignored.
- R5: Event bit 6 pulses on an advancing tick when the whole new time word equals the whole alarm word.
- R6: A nonzero stopwatch count decrements by one per tick. Event bit 0 pulses on the tick that takes it from 1 to 0. A count of 0 stays at 0 and raises nothing.
- R7: A time load replaces the whole word in the next cycle. On a tick that coincides with the load, there is no increment and none of event bits 1 through 6 is raised. A stopwatch load on a tick takes priority over the decrement.
- R8: From day 32767 at 23:59:59, one tick gives an all-zero word. Bits 2, 3, 4 and 5 pulse, and no other overflow indication is given.
- R9: Without a tick, the time word holds and every event bit stays 0.
- R10: Each event strobe lasts exactly one cycle per qualifying tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle slow tick (one second) |
| time_ld | input | 1 | Load the time word |
| time_ld_val | input | 17+DAY_W | Time value to load |
| alarm_ld | input | 1 | Load the alarm word |
| alarm_ld_val | input | 17+DAY_W | Alarm value to load |
| sw_ld | input | 1 | Load the stopwatch count |
| sw_ld_val | input | SW_W | Stopwatch value to load |
| time_q | output | 17+DAY_W | Current packed time |
| evt_q | output | 7 | Event strobes: 6 alarm with day, 5 day wrap, 4 hour wrap, 3 minute wrap, 2 second, 1 alarm time-of-day, 0 stopwatch |

## Verification
The bench builds the block with its default parameters: a 15-bit day field and a 16-bit stopwatch. With those values the packed word is exactly 32 bits, and the bench's model can work in total seconds modulo 32768 days. Direct loads of the time word reach the far corners, such as the last second of day 32767 and hour wraps on arbitrary days, without waiting for millions of ticks. Random stretches use loads of alarms set one second ahead, so both alarm modes fire often, and they mix in short stopwatch counts.

// File: rtl/packed_tod_counter.sv
module packed_tod_counter #(
  parameter int DAY_W = 15,
  parameter int SW_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               time_ld,
  input  logic [17+DAY_W-1:0] time_ld_val,
  input  logic               alarm_ld,
  input  logic [17+DAY_W-1:0] alarm_ld_val,
  input  logic               sw_ld,
  input  logic [SW_W-1:0]    sw_ld_val,
  output logic [17+DAY_W-1:0] time_q,
  output logic [6:0]         evt_q
);
  localparam int TW = 17 + DAY_W;

  logic [TW-1:0]   alm_q;
  logic [SW_W-1:0] sw_q;

  wire [5:0]       sec = time_q[5:0];
  wire [5:0]       mnt = time_q[11:6];
  wire [4:0]       hr  = time_q[16:12];
  wire [DAY_W-1:0] day = time_q[TW-1:17];

  wire sec_wrap = sec >= 6'd59;
  wire min_wrap = sec_wrap && (mnt >= 6'd59);
  wire hr_wrap  = min_wrap && (hr >= 5'd23);

  wire [5:0]       sec_n = sec_wrap ? 6'd0 : sec + 6'd1;
  wire [5:0]       mnt_n = !sec_wrap ? mnt : (mnt >= 6'd59 ? 6'd0 : mnt + 6'd1);
  wire [4:0]       hr_n  = !min_wrap ? hr : (hr >= 5'd23 ? 5'd0 : hr + 5'd1);
  wire [DAY_W-1:0] day_n = hr_wrap ? day + {{(DAY_W-1){1'b0}}, 1'b1} : day;
  wire [TW-1:0]    inc   = {day_n, hr_n, mnt_n, sec_n};

  wire advance = tick_en && !time_ld;
  wire sw_fire = tick_en && !sw_ld && (sw_q == {{(SW_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q <= '0;
      alm_q  <= '0;
      sw_q   <= '0;
      evt_q  <= '0;
    end else begin
      evt_q <= {advance && (inc == alm_q),
                advance && hr_wrap,
                advance && min_wrap,
                advance && sec_wrap,
                advance,
                advance && (inc[16:0] == alm_q[16:0]),
                sw_fire};
      if (time_ld)      time_q <= time_ld_val;
      else if (tick_en) time_q <= inc;
      if (alarm_ld) alm_q <= alarm_ld_val;
      if (sw_ld)                    sw_q <= sw_ld_val;
      else if (tick_en && sw_q != '0) sw_q <= sw_q - {{(SW_W-1){1'b0}}, 1'b1};
    end
  end
endmodule

module packed_tod_checks #(
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          time_ld,
  input logic [TW-1:0] time_ld_val,
  input logic [TW-1:0] time_q,
  input logic [6:0]    evt_q
);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !time_ld) |=> $stable(time_q));
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> (evt_q == 7'd0));
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    time_ld |=> (time_q == $past(time_ld_val)));
  a_r7_no_evt: assert property (@(posedge clk) disable iff (!rst_n)
    time_ld |=> (evt_q[6:1] == 6'd0));
  a_r3_min_sec: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q[3] |-> evt_q[2]);
  a_r3_hr_min: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q[4] |-> evt_q[3]);
  a_r3_day_hr: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q[5] |-> evt_q[4]);
  a_r5_day_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q[6] |-> evt_q[1]);
  a_r2_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !time_ld && time_q[5:0] < 6'd59) |=>
      (time_q[5:0] == $past(time_q[5:0]) + 6'd1));
endmodule

bind packed_tod_counter packed_tod_checks #(.TW(17 + DAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .time_ld(time_ld),
  .time_ld_val(time_ld_val), .time_q(time_q), .evt_q(evt_q));

// File: tb/packed_tod_counter_tb_top.sv
module packed_tod_counter_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick_en = 0, time_ld = 0, alarm_ld = 0, sw_ld = 0;
  logic [31:0] time_ld_val = 0, alarm_ld_val = 0;
  logic [15:0] sw_ld_val = 0;
  logic [31:0] time_q;
  logic [6:0]  evt_q;

  int checks = 0, fails = 0;
  logic [31:0] m_t = 0, m_a = 0;
  logic [15:0] m_sw = 0;

  always #10 clk = ~clk;

  packed_tod_counter dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .time_ld(time_ld),
    .time_ld_val(time_ld_val), .alarm_ld(alarm_ld), .alarm_ld_val(alarm_ld_val),
    .sw_ld(sw_ld), .sw_ld_val(sw_ld_val), .time_q(time_q), .evt_q(evt_q));

  function automatic logic [31:0] mk(int d, int h, int m, int s);
    logic [31:0] r;
    r = {d[14:0], h[4:0], m[5:0], s[5:0]};
    return r;
  endfunction

  function automatic logic [31:0] next_sec(logic [31:0] t);
    longint tot;
    tot = ((longint'(t[31:17]) * 24 + t[16:12]) * 60 + t[11:6]) * 60 + t[5:0];
    tot = (tot + 1) % (longint'(32768) * 86400);
    return mk(int'(tot / 86400), int'((tot / 3600) % 24), int'((tot / 60) % 60), int'(tot % 60));
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(string tag, bit tk, bit tl = 0, logic [31:0] tv = 0,
                      bit al = 0, logic [31:0] av = 0, bit sl = 0, logic [15:0] sv = 0);
    logic [6:0]  e;
    logic [31:0] nt;
    tick_en = tk; time_ld = tl; time_ld_val = tv;
    alarm_ld = al; alarm_ld_val = av; sw_ld = sl; sw_ld_val = sv;
    @(posedge clk);
    e = 0;
    if (tk && !tl) begin
      nt = next_sec(m_t);
      e[2] = 1;
      e[3] = (nt[5:0] == 0);
      e[4] = (nt[11:0] == 0);
      e[5] = (nt[16:0] == 0);
      e[1] = (nt[16:0] == m_a[16:0]);
      e[6] = (nt == m_a);
      m_t = nt;
    end
    if (tl) m_t = tv;
    if (tk && !sl && m_sw == 1) e[0] = 1;
    if (sl) m_sw = sv;
    else if (tk && m_sw != 0) m_sw = m_sw - 1;
    if (al) m_a = av;
    @(negedge clk);
    chk({tag, " time"}, time_q, m_t);
    chk({tag, " evt"}, {25'd0, evt_q}, {25'd0, e});
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 time", time_q, 0);
    chk("R1 evt", {25'd0, evt_q}, 0);
    // R2 counting from zero
    repeat (5) step("R2", 1);
    // R9 no tick holds
    repeat (3) step("R9", 0);
    // R3 full-day rollover
    step("R3", 0, 1, mk(5, 23, 59, 59));
    step("R3", 1);
    step("R10", 0);
    step("R3", 0, 1, mk(7, 4, 59, 59));
    step("R3", 1);
    // R8 day counter wrap
    step("R8", 0, 1, mk(32767, 23, 59, 59));
    step("R8", 1);
    chk("R8 zero", time_q, 0);
    // R4 time-of-day alarm, other day
    step("R4", 0, 1, mk(2, 10, 20, 29), 1, mk(9, 10, 20, 30));
    step("R4", 1);
    // R5 full alarm
    step("R5", 0, 1, mk(9, 10, 20, 29));
    step("R5", 1);
    step("R10", 1);
    // R6 stopwatch
    step("R6", 0, 0, 0, 0, 0, 1, 16'd3);
    repeat (5) step("R6", 1);
    step("R6", 1, 0, 0, 0, 0, 1, 16'd0);
    step("R6", 1);
    // R7 load on a tick wins, stopwatch load on tick wins
    step("R7", 1, 1, mk(100, 1, 2, 3), 0, 0, 1, 16'd1);
    chk("R7 loaded", time_q, mk(100, 1, 2, 3));
    step("R7", 1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit tk, tl, al, sl;
      logic [31:0] tv, av;
      tk = ($urandom % 2) == 0;
      tl = ($urandom % 40) == 0;
      al = ($urandom % 25) == 0;
      sl = ($urandom % 20) == 0;
      tv = ($urandom % 3 == 0) ? mk($urandom % 32768, $urandom % 24, 59, 59 - ($urandom % 2))
                               : mk($urandom % 32768, $urandom % 24, $urandom % 60, $urandom % 60);
      av = ($urandom % 2) ? next_sec(m_t) : mk($urandom % 32768, m_t[16:12], m_t[11:6], m_t[5:0] + 2);
      step("R2", tk, tl, tv, al, av, sl, 16'($urandom % 8));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule